// File: doc/BRIEF.md
# Multiplexed Bus Cycle Strobe Decoder

This block sits on the bus side of a 16-bit processor whose address and data share one set of lines. Early in a cycle an address strobe captures the bus value into an address register. Later, an active-low data strobe opens the data phase. A memory/IO qualifier and a read/write direction then pick exactly one of four active-low strobes: memory read, memory write, I/O read or I/O write. Two reserved I/O locations raise extra strobes. An I/O write to 0x1000 raises the interrupt-acknowledge strobe. An I/O read from 0x8410 raises the configuration enable.

A 17th bus line carries odd parity. The block drives that bit during write data phases and checks it during read data phases. A mismatch produces a one-clock error pulse. The block also owns the direction of the shared bus. It drives read data only in a read data phase.

An active-low strobe-enable input can release the address outputs and the four read/write strobes to high impedance. Each of these two groups has its own permit bit, and the group floats only when its permit bit is set. All inputs are sampled on the rising clock. The pad drivers themselves sit outside the block and are steered by drive-enable outputs.

Top module: `mbsd_bus_iface`

## Requirements
- R1: While reset is held, and until the reset synchronizer releases two clocks after `rst_n` rises, every active-low strobe is 1 and `bus_oe`, `par_oe`, `par_err`, `par_out` are 0 and `addr_out` is 0.
- R2: On each clock where `addr_stb` is sampled 1, `addr_out` takes the sampled `bus_in` after that edge. Otherwise it holds its value.
- R3: One clock after `data_stb_n` is sampled 0 with `mem_sel`=1 (1 selects memory), `mem_rd_n` goes low if `rd_wr`=1 (1 means read), or `mem_wr_n` goes low if `rd_wr`=0.
- R4: One clock after `data_stb_n` is sampled 0 with `mem_sel`=0, `io_rd_n` goes low if `rd_wr`=1, or `io_wr_n` goes low if `rd_wr`=0.
- R5: One clock after `data_stb_n` is sampled 1, all four read/write strobes are high. At no time is more than one of them low.
- R6: `int_ack_n` is low exactly in the clocks where `io_wr_n` is low because of a write sampled while the address register held 0x1000.
- R7: `cfg_en_n` is low exactly in the clocks where `io_rd_n` is low because of a read sampled while the address register held 0x8410. An I/O write to that address does not assert it.
- R8: `bus_oe` is 1 exactly in the clocks where a read strobe (memory or I/O) is low. `bus_out` always equals `rd_data`.
- R9: `par_oe` is 1 exactly in the clocks where a write strobe is low. On each clock where a write data phase is sampled, `par_out` becomes the bit that makes the ones count of {`bus_in`, `par_out`} odd. Otherwise `par_out` holds.
- R10: When the first clock of a read data phase (strobe sampled 0 while no strobe was low) sees {`bus_in`, `par_in`} with an even ones count, `par_err` is 1 for exactly the next clock. Later clocks of the same phase raise no error.
- R11: `addr_drv` is 0 only when both `float_addr_ok` and `strb_en_n` are 1. It follows these inputs without a clock.
- R12: `strb_drv` is 0 only when both `float_strb_ok` and `strb_en_n` are 1. `int_ack_n` and `cfg_en_n` are unaffected by either float control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 16 | Value seen on the shared address/data lines |
| par_in | input | 1 | Value seen on the parity line |
| addr_stb | input | 1 | Address capture strobe, active high |
| data_stb_n | input | 1 | Data phase strobe, active low |
| mem_sel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| rd_data | input | 16 | Data to place on the bus during reads |
| strb_en_n | input | 1 | Active-low strobe enable; 1 requests float |
| float_addr_ok | input | 1 | Permit bit letting the address group float |
| float_strb_ok | input | 1 | Permit bit letting the strobe group float |
| addr_out | output | 16 | Captured address |
| addr_drv | output | 1 | Drive enable for the address pads |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| strb_drv | output | 1 | Drive enable for the four read/write strobe pads |
| int_ack_n | output | 1 | Interrupt-acknowledge strobe, active low |
| cfg_en_n | output | 1 | Configuration enable, active low |
| bus_out | output | 16 | Data driven onto the bus |
| bus_oe | output | 1 | Drive enable for the bus pads |
| par_out | output | 1 | Parity bit driven during writes |
| par_oe | output | 1 | Drive enable for the parity pad |
| par_err | output | 1 | One-clock parity mismatch pulse |

## Verification
The bench builds the block with its defaults: a 16-bit bus, 0x1000 as the acknowledge location and 0x8410 as the configuration location. It is built this way so that directed cycles can hit those two addresses exactly, and their neighbours such as 0x1001, as well as the wrong direction at each. Random traffic leans toward those two addresses. It also toggles the strobe and float controls every clock, which brings in back-to-back data phases, an address capture overlapping a data phase, and every combination of float permits.

// File: rtl/mbsd_pkg.sv
package mbsd_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_MEM_RD = 3'd1,
    CYC_MEM_WR = 3'd2,
    CYC_IO_RD  = 3'd3,
    CYC_IO_WR  = 3'd4
  } cyc_e;

  localparam int NUM_RW_STROBES = 4;

  function automatic cyc_e classify(input logic active, input logic is_mem,
                                    input logic is_rd);
    cyc_e k;
    if (!active)      k = CYC_IDLE;
    else if (is_mem)  k = is_rd ? CYC_MEM_RD : CYC_MEM_WR;
    else              k = is_rd ? CYC_IO_RD  : CYC_IO_WR;
    return k;
  endfunction

  function automatic logic is_read(input cyc_e k);
    return (k == CYC_MEM_RD) || (k == CYC_IO_RD);
  endfunction

  function automatic logic is_write(input cyc_e k);
    return (k == CYC_MEM_WR) || (k == CYC_IO_WR);
  endfunction

endpackage

// File: rtl/mbsd_addr_latch.sv
module mbsd_addr_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] addr_q
);

  logic [DW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (cap_en) addr_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

endmodule

// File: rtl/mbsd_strobe_gen.sv
module mbsd_strobe_gen
  import mbsd_pkg::*;
#(
  parameter int          DW        = 16,
  parameter logic [DW-1:0] IACK_ADDR = DW'(16'h1000),
  parameter logic [DW-1:0] CFG_ADDR  = DW'(16'h8410)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_stb_n,
  input  logic          mem_sel,
  input  logic          rd_wr,
  input  logic [DW-1:0] addr_q,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          io_rd_n,
  output logic          io_wr_n,
  output logic          int_ack_n,
  output logic          cfg_en_n,
  output logic          rd_phase,
  output logic          wr_phase,
  output logic          rd_start,
  output logic          wr_sample
);

  cyc_e kind_d, kind_q;
  logic iack_d, iack_q;
  logic cfg_d, cfg_q;
  logic [NUM_RW_STROBES-1:0] strb_n;

  // next state
  always_comb begin
    kind_d = classify(!data_stb_n, mem_sel, rd_wr);
    iack_d = (kind_d == CYC_IO_WR) && (addr_q == IACK_ADDR);
    cfg_d  = (kind_d == CYC_IO_RD) && (addr_q == CFG_ADDR);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CYC_IDLE;
      iack_q <= 1'b0;
      cfg_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      iack_q <= iack_d;
      cfg_q  <= cfg_d;
    end
  end

  // one active-low strobe per non-idle cycle kind, index g maps to code g+1
  for (genvar g = 0; g < NUM_RW_STROBES; g++) begin : g_strb
    assign strb_n[g] = (kind_q != cyc_e'(g + 1));
  end

  assign mem_rd_n  = strb_n[0];
  assign mem_wr_n  = strb_n[1];
  assign io_rd_n   = strb_n[2];
  assign io_wr_n   = strb_n[3];
  assign int_ack_n = !iack_q;
  assign cfg_en_n  = !cfg_q;
  assign rd_phase  = is_read(kind_q);
  assign wr_phase  = is_write(kind_q);
  assign rd_start  = is_read(kind_d) && (kind_q == CYC_IDLE);
  assign wr_sample = is_write(kind_d);

endmodule

// File: rtl/mbsd_parity.sv
module mbsd_parity #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sample,
  input  logic          rd_start,
  input  logic [DW-1:0] bus_in,
  input  logic          par_in,
  output logic          par_out,
  output logic          par_err
);

  logic par_d, par_q;
  logic err_d, err_q;
  logic par_en;

  always_comb begin
    par_en = wr_sample;
    par_d  = par_q;
    if (par_en) par_d = ~(^bus_in);
    // odd parity: ones count of data plus parity bit must be odd
    err_d  = rd_start && !(^{bus_in, par_in});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      par_q <= par_d;
      err_q <= err_d;
    end
  end

  assign par_out = par_q;
  assign par_err = err_q;

endmodule

// File: rtl/mbsd_pad_ctl.sv
module mbsd_pad_ctl #(
  parameter int N_GRP = 2
) (
  input  logic             strb_en_n,
  input  logic [N_GRP-1:0] float_ok,
  output logic [N_GRP-1:0] drv
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign drv[g] = !(float_ok[g] && strb_en_n);
  end

endmodule

// File: rtl/mbsd_bus_iface.sv
module mbsd_bus_iface #(
  parameter int            DW        = 16,
  parameter logic [DW-1:0] IACK_ADDR = DW'(16'h1000),
  parameter logic [DW-1:0] CFG_ADDR  = DW'(16'h8410),
  parameter int            RST_SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          par_in,
  input  logic          addr_stb,
  input  logic          data_stb_n,
  input  logic          mem_sel,
  input  logic          rd_wr,
  input  logic [DW-1:0] rd_data,
  input  logic          strb_en_n,
  input  logic          float_addr_ok,
  input  logic          float_strb_ok,
  output logic [DW-1:0] addr_out,
  output logic          addr_drv,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          io_rd_n,
  output logic          io_wr_n,
  output logic          strb_drv,
  output logic          int_ack_n,
  output logic          cfg_en_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          par_out,
  output logic          par_oe,
  output logic          par_err
);

  localparam int N_GRP = 2;

  logic [RST_SYNC-1:0] rs_q;
  logic                rst_int;
  logic                rd_phase, wr_phase, rd_start, wr_sample;
  logic [N_GRP-1:0]    grp_float_ok, grp_drv;

  // reset: asserted at once, released after RST_SYNC clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int = rs_q[RST_SYNC-1];

  mbsd_addr_latch #(.DW(DW)) u_alat (
    .clk    (clk),
    .rst_n  (rst_int),
    .cap_en (addr_stb),
    .bus_in (bus_in),
    .addr_q (addr_out)
  );

  mbsd_strobe_gen #(
    .DW        (DW),
    .IACK_ADDR (IACK_ADDR),
    .CFG_ADDR  (CFG_ADDR)
  ) u_sgen (
    .clk        (clk),
    .rst_n      (rst_int),
    .data_stb_n (data_stb_n),
    .mem_sel    (mem_sel),
    .rd_wr      (rd_wr),
    .addr_q     (addr_out),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n),
    .int_ack_n  (int_ack_n),
    .cfg_en_n   (cfg_en_n),
    .rd_phase   (rd_phase),
    .wr_phase   (wr_phase),
    .rd_start   (rd_start),
    .wr_sample  (wr_sample)
  );

  mbsd_parity #(.DW(DW)) u_par (
    .clk       (clk),
    .rst_n     (rst_int),
    .wr_sample (wr_sample),
    .rd_start  (rd_start),
    .bus_in    (bus_in),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_err   (par_err)
  );

  assign grp_float_ok = {float_strb_ok, float_addr_ok};

  mbsd_pad_ctl #(.N_GRP(N_GRP)) u_pad (
    .strb_en_n (strb_en_n),
    .float_ok  (grp_float_ok),
    .drv       (grp_drv)
  );

  assign addr_drv = grp_drv[0];
  assign strb_drv = grp_drv[1];
  assign bus_out  = rd_data;
  assign bus_oe   = rd_phase;
  assign par_oe   = wr_phase;

endmodule

// File: rtl/mbsd_bus_iface_chk.sv
module mbsd_bus_iface_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_int,
  input logic          addr_stb,
  input logic [DW-1:0] addr_out,
  input logic          mem_rd_n,
  input logic          mem_wr_n,
  input logic          io_rd_n,
  input logic          io_wr_n,
  input logic          int_ack_n,
  input logic          cfg_en_n,
  input logic          bus_oe,
  input logic          par_oe,
  input logic          par_err
);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_int)
    !addr_stb |=> $stable(addr_out));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_int)
    $onehot0({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}));

  assert_iack_with_iowr_R6: assert property (@(posedge clk) disable iff (!rst_int)
    !int_ack_n |-> !io_wr_n);

  assert_cfg_with_iord_R7: assert property (@(posedge clk) disable iff (!rst_int)
    !cfg_en_n |-> !io_rd_n);

  assert_dir_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_int)
    !(bus_oe && par_oe));

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_int)
    par_err |=> !par_err);

endmodule

bind mbsd_bus_iface mbsd_bus_iface_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_int   (rst_int),
  .addr_stb  (addr_stb),
  .addr_out  (addr_out),
  .mem_rd_n  (mem_rd_n),
  .mem_wr_n  (mem_wr_n),
  .io_rd_n   (io_rd_n),
  .io_wr_n   (io_wr_n),
  .int_ack_n (int_ack_n),
  .cfg_en_n  (cfg_en_n),
  .bus_oe    (bus_oe),
  .par_oe    (par_oe),
  .par_err   (par_err)
);

// File: tb/sim_mbsd_bus_iface.sv
module sim_mbsd_bus_iface;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk;
  logic rst_n;
  logic [DW-1:0] bus_in, rd_data;
  logic par_in, addr_stb, data_stb_n, mem_sel, rd_wr;
  logic strb_en_n, float_addr_ok, float_strb_ok;
  logic [DW-1:0] addr_out, bus_out;
  logic addr_drv, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, strb_drv;
  logic int_ack_n, cfg_en_n, bus_oe, par_out, par_oe, par_err;

  mbsd_bus_iface u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .par_in(par_in),
    .addr_stb(addr_stb), .data_stb_n(data_stb_n), .mem_sel(mem_sel),
    .rd_wr(rd_wr), .rd_data(rd_data), .strb_en_n(strb_en_n),
    .float_addr_ok(float_addr_ok), .float_strb_ok(float_strb_ok),
    .addr_out(addr_out), .addr_drv(addr_drv), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .strb_drv(strb_drv), .int_ack_n(int_ack_n), .cfg_en_n(cfg_en_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .par_out(par_out),
    .par_oe(par_oe), .par_err(par_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state: cycle kind 0 idle,1 mem rd,2 mem wr,3 io rd,4 io wr
  bit       m_rs1, m_rs2;
  bit [15:0] m_addr;
  int       m_kind;
  bit       m_iack, m_cfg, m_par, m_err;

  task automatic model_clear();
    m_addr = '0; m_kind = 0; m_iack = 0; m_cfg = 0; m_par = 0; m_err = 0;
  endtask

  task automatic model_edge();
    int nk;
    bit old_rs2;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_clear();
    end else begin
      old_rs2 = m_rs2;
      m_rs2 = m_rs1; m_rs1 = 1;
      if (!old_rs2) model_clear();
      else begin
        if (data_stb_n) nk = 0;
        else if (mem_sel) nk = rd_wr ? 1 : 2;
        else nk = rd_wr ? 3 : 4;
        m_iack = (nk == 4) && (m_addr == 16'h1000);
        m_cfg  = (nk == 3) && (m_addr == 16'h8410);
        if (nk == 2 || nk == 4) m_par = ~(^bus_in);
        m_err  = (nk == 1 || nk == 3) && (m_kind == 0) && ((^{bus_in, par_in}) == 1'b0);
        m_kind = nk;
        if (addr_stb) m_addr = bus_in;
      end
    end
  endtask

  task automatic chk(input string tag, input string nm, input logic [15:0] act,
                     input logic [15:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit in_rst;
    in_rst = !m_rs2;
    n_vec++;
    chk(in_rst ? "R1" : "R2", "addr_out", addr_out, m_addr);
    chk(in_rst ? "R1" : "R3", "mem_rd_n", 16'(mem_rd_n), 16'(m_kind != 1));
    chk(in_rst ? "R1" : "R3", "mem_wr_n", 16'(mem_wr_n), 16'(m_kind != 2));
    chk(in_rst ? "R1" : "R4", "io_rd_n",  16'(io_rd_n),  16'(m_kind != 3));
    chk(in_rst ? "R1" : "R4", "io_wr_n",  16'(io_wr_n),  16'(m_kind != 4));
    chk("R5", "strobes_low_count",
        16'($countones({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n})), 16'(m_kind != 0));
    chk(in_rst ? "R1" : "R6", "int_ack_n", 16'(int_ack_n), 16'(!m_iack));
    chk(in_rst ? "R1" : "R7", "cfg_en_n",  16'(cfg_en_n),  16'(!m_cfg));
    chk(in_rst ? "R1" : "R8", "bus_oe", 16'(bus_oe), 16'(m_kind == 1 || m_kind == 3));
    chk("R8", "bus_out", bus_out, rd_data);
    chk(in_rst ? "R1" : "R9", "par_oe", 16'(par_oe), 16'(m_kind == 2 || m_kind == 4));
    chk(in_rst ? "R1" : "R9", "par_out", 16'(par_out), 16'(m_par));
    chk(in_rst ? "R1" : "R10", "par_err", 16'(par_err), 16'(m_err));
    chk("R11", "addr_drv", 16'(addr_drv), 16'(!(float_addr_ok && strb_en_n)));
    chk("R12", "strb_drv", 16'(strb_drv), 16'(!(float_strb_ok && strb_en_n)));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic bus_cycle(input logic [15:0] adr, input logic msel, input logic rw,
                           input logic [15:0] dat, input bit good_par, input int hold);
    addr_stb = 1; data_stb_n = 1; bus_in = adr; step();
    addr_stb = 0; bus_in = dat; par_in = good_par ? ~(^dat) : ^dat;
    rd_data = dat ^ 16'h5A5A; step();
    data_stb_n = 0; mem_sel = msel; rd_wr = rw;
    for (int i = 0; i < hold; i++) step();
    data_stb_n = 1; step();
  endtask

  initial begin
    rst_n = 0; bus_in = '0; rd_data = '0; par_in = 0; addr_stb = 0;
    data_stb_n = 1; mem_sel = 0; rd_wr = 0; strb_en_n = 0;
    float_addr_ok = 0; float_strb_ok = 0;
    m_rs1 = 0; m_rs2 = 0; model_clear();
    // R1: reset state, including synchronizer release
    for (int i = 0; i < 4; i++) step();
    rst_n = 1;
    for (int i = 0; i < 4; i++) step();
    // R3 memory cycles
    bus_cycle(16'h0123, 1, 1, 16'hBEEF, 1, 3);
    bus_cycle(16'h4567, 1, 0, 16'hCAFE, 1, 2);
    // R4 / R10 I/O read with bad parity, held for several clocks
    bus_cycle(16'h0042, 0, 1, 16'h0F0F, 0, 4);
    bus_cycle(16'h0044, 0, 0, 16'h0001, 1, 2);
    // R6 acknowledge location and neighbours
    bus_cycle(16'h1000, 0, 0, 16'h00FF, 1, 3);
    bus_cycle(16'h1001, 0, 0, 16'h00FF, 1, 2);
    bus_cycle(16'h1000, 1, 0, 16'h1234, 1, 2);
    bus_cycle(16'h1000, 0, 1, 16'h1234, 1, 2);
    // R7 configuration location
    bus_cycle(16'h8410, 0, 1, 16'h7777, 1, 3);
    bus_cycle(16'h8410, 0, 0, 16'h7777, 1, 2);
    bus_cycle(16'h8411, 0, 1, 16'h7777, 1, 2);
    bus_cycle(16'h8410, 1, 1, 16'h7777, 0, 2);
    // R11 / R12 all float control combinations
    for (int c = 0; c < 8; c++) begin
      {strb_en_n, float_addr_ok, float_strb_ok} = 3'(c);
      bus_cycle(16'h1000, 0, 0, 16'(c), 1, 1);
    end
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      addr_stb = ($urandom_range(0, 3) == 0);
      bus_in = (r == 0) ? 16'h1000 : (r == 1) ? 16'h8410 : 16'($urandom);
      par_in = 1'($urandom);
      rd_data = 16'($urandom);
      data_stb_n = ($urandom_range(0, 2) == 0);
      mem_sel = 1'($urandom); rd_wr = 1'($urandom);
      strb_en_n = 1'($urandom); float_addr_ok = 1'($urandom);
      float_strb_ok = 1'($urandom);
      if (i == 2000) rst_n = 0;
      if (i == 2003) rst_n = 1;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule